// File: doc/BRIEF.md
# Ping-Pong Buffer DMA Channel

This block is one DMA channel with two address/limit register sets, called A and B. The channel works through them in turn. While one set drives transfers, software refills the other. Each transfer unit is one data word of `DW` bits. A unit moves between a peripheral and a memory port. The peripheral uses a request/acknowledge handshake. The memory port is a simple request/grant port. A control bit picks the direction.

Each limit register holds the in-page offset of the final unit in its buffer, not a byte count. It also carries two flags, stop and last. An interrupt line stays high while the channel is enabled and still active but one of its buffer sets is empty.

Software finds the set to load next by XOR-ing two status bits. An all-zero address with both flags set is a terminal marker that ends the channel's activity.

Top module: `pingpong_dma`

## Requirements
- R1: After reset the status word reads 4: bit2, the overflow bit, is 1. Bit1 (interrupt) and bit0 (active buffer, 1 = B) are 0, and the control word reads 0. A control write with bit6 (clear) set does four things: it invalidates both buffers, points the channel at A, cancels any finished condition and aborts the unit in flight.
- R2: The register index `reg_addr` has six registers. Writes and reads always act on the register at that index:

  | Index | Register |
  |---|---|
  | 0 | A current address |
  | 1 | A limit |
  | 2 | B current address |
  | 3 | B limit |
  | 4 | control |
  | 5 | status |

  Control bit7 is enable, bit5 is direction and bits4:0 are the unit-size field, which reads back unchanged. Clear always reads 0. A limit reads back as bit31 stop, bit30 last and bits11:0 offset.
- R3: The status word has three bits: bit0 (active buffer), bit1 (interrupt, equal to `irq`) and bit2 (overflow). Overflow is 1 exactly when both buffers are empty. Software loads A next when bit2 XOR bit0 is 1, and loads B next when it is 0.
- R4: Writing a limit register marks that buffer valid. `irq` is high when the channel is enabled, not finished, and at least one buffer is invalid.
- R5: Buffers are used in turn. A runs first after a clear, and each time a buffer completes, the active pointer moves to the other buffer.
- R6: Each unit is done at the buffer's current address. After the unit, the address grows by DW/8 within the 4 KiB page; bits above 11 stay fixed and the offset wraps. The buffer completes with the unit whose offset is greater than or equal to the limit offset.
- R7: When the active buffer is empty, no unit starts. When both buffers are empty, overflow reads 1. Loading the active buffer resumes the transfers.
- R8: With direction 0, each unit does a memory read and then a one-cycle `dev_ack` that drives the read data onto `dev_wdata`.
- R9: With direction 1, each unit does a one-cycle `dev_ack` that captures `dev_rdata`, and then a memory write of that data at the current address.
- R10: When a buffer whose stop flag is set completes, the channel finishes. No further units run and `irq` is 0 until a clear.
- R11: When the active buffer holds the terminal marker, the channel finishes without any unit and invalidates that buffer. The terminal marker is current address 0 with both stop and last set.
- R12: While enable is 0, no unit starts, even with a valid buffer and a pending request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Service request: a buffer needs loading |
| dev_req | input | 1 | Peripheral wants a unit |
| dev_ack | output | 1 | One-cycle unit acknowledge to the peripheral |
| dev_rdata | input | DW | Data from the peripheral (direction 1) |
| dev_wdata | output | DW | Data to the peripheral (direction 0) |
| mem_req | output | 1 | Memory access request, held until grant |
| mem_we | output | 1 | Memory write when 1, read when 0 |
| mem_addr | output | AW | Byte address of the access |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, valid with grant |
| mem_gnt | input | 1 | Memory grant: access completes this cycle |

## Verification
A register write takes effect at the next clock edge. Status and read-back values are therefore sampled on the falling edge right after the write.

With direction 0, a unit's address advance and any buffer switch happen at the edge that ends its acknowledge cycle. With direction 1, they happen at the edge of the memory grant. That grant can come several cycles after the acknowledge, because the memory model withholds grants on a pseudo-random pattern.

The bench therefore waits for the expected acknowledge count and then adds a fixed margin of twelve cycles before it reads status, addresses or memory. The "nothing happens" cases (overflow pause, disabled channel, stop, terminal marker) keep the peripheral request high for twenty cycles and check that the acknowledge count has not moved.

// File: rtl/pingpong_dma_pkg.sv
package pingpong_dma_pkg;
   // register indices (buffer sets at 2*n and 2*n+1)
   localparam int REG_CTRL = 4;
   localparam int REG_STAT = 5;
   // control fields
   localparam int CTRL_EN  = 7;
   localparam int CTRL_CLR = 6;
   localparam int CTRL_DIR = 5;
   localparam int SIZE_W   = 5;
   // limit register flags
   localparam int LIM_STOP = 31;
   localparam int LIM_LAST = 30;

   typedef enum logic [1:0] {
      XF_IDLE = 2'd0,
      XF_DEV  = 2'd1,
      XF_MEM  = 2'd2
   } xfer_state_e;
endpackage

// File: rtl/pingpong_dma_bufset.sv
module pingpong_dma_bufset #(
   parameter int AW        = 32,
   parameter int PAGE_BITS = 12,
   parameter int STEP      = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clr,
   input  logic                 wr_cur,
   input  logic                 wr_lim,
   input  logic [AW-1:0]        cur_in,
   input  logic [PAGE_BITS-1:0] off_in,
   input  logic                 stop_in,
   input  logic                 last_in,
   input  logic                 adv,
   input  logic                 kill,
   output logic [AW-1:0]        cur,
   output logic [31:0]          lim_word,
   output logic                 valid,
   output logic                 final_unit,
   output logic                 stop_flag,
   output logic                 terminal
);
   localparam logic [PAGE_BITS-1:0] STEP_V = PAGE_BITS'(STEP);

   logic [AW-1:0]        cur_q;
   logic [PAGE_BITS-1:0] off_q;
   logic                 stop_q, last_q, valid_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur_q   <= '0;
         off_q   <= '0;
         stop_q  <= 1'b0;
         last_q  <= 1'b0;
         valid_q <= 1'b0;
      end else begin
         if (wr_cur)
            cur_q <= cur_in;
         else if (adv)
            cur_q <= {cur_q[AW-1:PAGE_BITS], cur_q[PAGE_BITS-1:0] + STEP_V};
         if (wr_lim) begin
            off_q  <= off_in;
            stop_q <= stop_in;
            last_q <= last_in;
         end
         if (clr)
            valid_q <= 1'b0;
         else if (wr_lim)
            valid_q <= 1'b1;
         else if (kill || (adv && final_unit))
            valid_q <= 1'b0;
      end
   end

   assign cur        = cur_q;
   assign valid      = valid_q;
   assign stop_flag  = stop_q;
   assign final_unit = (cur_q[PAGE_BITS-1:0] >= off_q);
   assign terminal   = stop_q && last_q && (cur_q == '0);
   assign lim_word   = {stop_q, last_q, {(30-PAGE_BITS){1'b0}}, off_q};
endmodule

// File: rtl/pingpong_dma_xfer.sv
module pingpong_dma_xfer
   import pingpong_dma_pkg::*;
#(
   parameter int AW = 32,
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          start,
   input  logic          dir,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] dev_rdata,
   input  logic [DW-1:0] mem_rdata,
   input  logic          mem_gnt,
   output logic          idle,
   output logic          unit_done,
   output logic          dev_ack,
   output logic [DW-1:0] dev_wdata,
   output logic          mem_req,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata
);
   xfer_state_e   state_q;
   logic          dir_q;
   logic [DW-1:0] data_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= XF_IDLE;
         dir_q   <= 1'b0;
         data_q  <= '0;
      end else if (clr) begin
         state_q <= XF_IDLE;
      end else begin
         case (state_q)
            XF_IDLE: if (start) begin
               dir_q   <= dir;
               state_q <= dir ? XF_DEV : XF_MEM;
            end
            XF_DEV: if (dir_q) begin
               data_q  <= dev_rdata;
               state_q <= XF_MEM;
            end else begin
               state_q <= XF_IDLE;
            end
            XF_MEM: if (mem_gnt) begin
               if (!dir_q) begin
                  data_q  <= mem_rdata;
                  state_q <= XF_DEV;
               end else begin
                  state_q <= XF_IDLE;
               end
            end
            default: state_q <= XF_IDLE;
         endcase
      end
   end

   assign idle      = (state_q == XF_IDLE);
   assign dev_ack   = (state_q == XF_DEV);
   assign mem_req   = (state_q == XF_MEM);
   assign mem_we    = dir_q;
   assign mem_addr  = addr;
   assign mem_wdata = data_q;
   assign dev_wdata = data_q;
   assign unit_done = ((state_q == XF_DEV) && !dir_q) ||
                      ((state_q == XF_MEM) && mem_gnt && dir_q);
endmodule

// File: rtl/pingpong_dma.sv
module pingpong_dma
   import pingpong_dma_pkg::*;
#(
   parameter int AW        = 32,
   parameter int DW        = 16,
   parameter int PAGE_BITS = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          reg_we,
   input  logic [2:0]    reg_addr,
   input  logic [31:0]   reg_wdata,
   output logic [31:0]   reg_rdata,
   output logic          irq,
   input  logic          dev_req,
   output logic          dev_ack,
   input  logic [DW-1:0] dev_rdata,
   output logic [DW-1:0] dev_wdata,
   output logic          mem_req,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata,
   input  logic [DW-1:0] mem_rdata,
   input  logic          mem_gnt
);
   localparam int UNIT_BYTES = DW / 8;
   localparam int NBUF       = 2;

   initial begin : param_check
      assert (DW == 8 || DW == 16 || DW == 32)
         else $error("pingpong_dma: DW must be 8, 16 or 32");
      assert (AW > PAGE_BITS && AW <= 32)
         else $error("pingpong_dma: AW must exceed PAGE_BITS and fit 32 bits");
      assert (PAGE_BITS >= 4 && PAGE_BITS <= 30)
         else $error("pingpong_dma: PAGE_BITS out of range");
   end

   logic              en_q, dir_q, act_q, done_q;
   logic [SIZE_W-1:0] size_q;
   logic              ctrl_wr, clr;
   logic              xf_idle, unit_done, start, term_hit;

   logic [AW-1:0]     cur_w [NBUF];
   logic [31:0]       lim_w [NBUF];
   logic [NBUF-1:0]   buf_valid, buf_final, buf_stop, buf_term;

   assign ctrl_wr = reg_we && (reg_addr == 3'(REG_CTRL));
   assign clr     = ctrl_wr && reg_wdata[CTRL_CLR];

   for (genvar g = 0; g < NBUF; g++) begin : g_buf
      pingpong_dma_bufset #(
         .AW(AW), .PAGE_BITS(PAGE_BITS), .STEP(UNIT_BYTES)
      ) i_bufset (
         .clk        (clk),
         .rst_n      (rst_n),
         .clr        (clr),
         .wr_cur     (reg_we && (reg_addr == 3'(2*g))),
         .wr_lim     (reg_we && (reg_addr == 3'(2*g+1))),
         .cur_in     (reg_wdata[AW-1:0]),
         .off_in     (reg_wdata[PAGE_BITS-1:0]),
         .stop_in    (reg_wdata[LIM_STOP]),
         .last_in    (reg_wdata[LIM_LAST]),
         .adv        (unit_done && (act_q == 1'(g))),
         .kill       (term_hit && (act_q == 1'(g))),
         .cur        (cur_w[g]),
         .lim_word   (lim_w[g]),
         .valid      (buf_valid[g]),
         .final_unit (buf_final[g]),
         .stop_flag  (buf_stop[g]),
         .terminal   (buf_term[g])
      );
   end

   logic run_ok;
   assign run_ok   = xf_idle && en_q && !done_q && buf_valid[act_q];
   assign start    = run_ok && !buf_term[act_q] && dev_req;
   assign term_hit = run_ok && buf_term[act_q];

   pingpong_dma_xfer #(.AW(AW), .DW(DW)) i_xfer (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (clr),
      .start     (start),
      .dir       (dir_q),
      .addr      (cur_w[act_q]),
      .dev_rdata (dev_rdata),
      .mem_rdata (mem_rdata),
      .mem_gnt   (mem_gnt),
      .idle      (xf_idle),
      .unit_done (unit_done),
      .dev_ack   (dev_ack),
      .dev_wdata (dev_wdata),
      .mem_req   (mem_req),
      .mem_we    (mem_we),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         dir_q  <= 1'b0;
         size_q <= '0;
         act_q  <= 1'b0;
         done_q <= 1'b0;
      end else begin
         if (ctrl_wr) begin
            en_q   <= reg_wdata[CTRL_EN];
            dir_q  <= reg_wdata[CTRL_DIR];
            size_q <= reg_wdata[SIZE_W-1:0];
         end
         if (clr) begin
            act_q  <= 1'b0;
            done_q <= 1'b0;
         end else begin
            if (unit_done && buf_final[act_q]) begin
               act_q <= ~act_q;
               if (buf_stop[act_q]) done_q <= 1'b1;
            end
            if (term_hit) done_q <= 1'b1;
         end
      end
   end

   logic ofl;
   assign ofl = (buf_valid == '0);
   assign irq = en_q && !done_q && !(&buf_valid);

   always_comb begin
      case (reg_addr)
         3'd0:    reg_rdata = 32'(cur_w[0]);
         3'd1:    reg_rdata = lim_w[0];
         3'd2:    reg_rdata = 32'(cur_w[1]);
         3'd3:    reg_rdata = lim_w[1];
         3'd4:    reg_rdata = {24'd0, en_q, 1'b0, dir_q, size_q};
         3'd5:    reg_rdata = {29'd0, ofl, irq, act_q};
         default: reg_rdata = 32'd0;
      endcase
   end
endmodule

// File: rtl/pingpong_dma_chk.sv
module pingpong_dma_chk #(
   parameter int AW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          dev_ack,
   input logic          mem_req,
   input logic          mem_gnt,
   input logic [AW-1:0] mem_addr,
   input logic          xf_idle,
   input logic          en,
   input logic [1:0]    buf_valid,
   input logic          term_hit
);
   // R8: acknowledge lasts a single cycle per unit
   p_ack_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      dev_ack |=> !dev_ack);

   // R6: a memory access waiting for grant keeps its request and address
   p_mem_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr)));

   // R7: both buffers empty while idle: no unit activity next cycle
   p_pause_ofl_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ((buf_valid == 2'b00) && xf_idle) |=> (!mem_req && !dev_ack));

   // R12: a disabled idle channel stays idle
   p_disabled_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && xf_idle) |=> xf_idle);

   // R11: reaching the terminal marker starts no unit
   p_term_r11: assert property (@(posedge clk) disable iff (!rst_n)
      term_hit |=> (xf_idle && !mem_req && !dev_ack));
endmodule

bind pingpong_dma pingpong_dma_chk #(.AW(AW)) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .dev_ack   (dev_ack),
   .mem_req   (mem_req),
   .mem_gnt   (mem_gnt),
   .mem_addr  (mem_addr),
   .xf_idle   (xf_idle),
   .en        (en_q),
   .buf_valid (buf_valid),
   .term_hit  (term_hit)
);

// File: tb/test_pingpong_dma.sv
module test_pingpong_dma;
   localparam int AW = 32;
   localparam int DW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_we = 1'b0;
   logic [2:0]    reg_addr = 3'd0;
   logic [31:0]   reg_wdata = 32'd0;
   logic [31:0]   reg_rdata;
   logic          irq, dev_req, dev_ack, mem_req, mem_we, mem_gnt;
   logic [DW-1:0] dev_rdata, dev_wdata, mem_wdata, mem_rdata;
   logic [AW-1:0] mem_addr;

   int unsigned   vectors = 0, miscompares = 0;
   int unsigned   ack_cnt = 0, want = 0;
   logic [7:0]    lfsr = 8'h5B;
   logic [15:0]   mem [0:255];
   logic [15:0]   rx  [0:255];

   always #10 clk = ~clk;

   pingpong_dma #(.AW(AW), .DW(DW), .PAGE_BITS(12)) i_pingpong_dma (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
      .dev_req(dev_req), .dev_ack(dev_ack), .dev_rdata(dev_rdata),
      .dev_wdata(dev_wdata), .mem_req(mem_req), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .mem_gnt(mem_gnt)
   );

   // peripheral and memory models
   assign dev_req   = (ack_cnt < want);
   assign dev_rdata = 16'h5A00 + ack_cnt[15:0];
   assign mem_gnt   = lfsr[0] | lfsr[2];
   assign mem_rdata = mem[mem_addr[8:1]];

   always @(posedge clk) begin
      lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      if (dev_ack) begin
         rx[ack_cnt[7:0]] <= dev_wdata;
         ack_cnt <= ack_cnt + 1;
      end
      if (mem_req && mem_gnt && mem_we)
         mem[mem_addr[8:1]] <= mem_wdata;
   end

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      vectors++;
      if (got !== exp) begin
         miscompares++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] v);
      reg_addr = a;
      #1 v = reg_rdata;
   endtask

   task automatic wait_acks(input int unsigned n);
      int t = 0;
      while (ack_cnt < n && t < 3000) begin
         @(negedge clk);
         t++;
      end
      repeat (12) @(negedge clk);
   endtask

   task automatic t_reset;
      logic [31:0] v;
      rd(3'd5, v); chk("R1 reset status", v, 32'd4);
      rd(3'd4, v); chk("R1 reset control", v, 32'd0);
      chk("R1 reset irq", {31'd0, irq}, 32'd0);
   endtask

   task automatic t_regs;
      logic [31:0] v;
      wr(3'd2, 32'h1234_5678);
      rd(3'd2, v); chk("R2 B current readback", v, 32'h1234_5678);
      wr(3'd3, 32'hC000_0ABC);
      rd(3'd3, v); chk("R2 B limit readback", v, 32'hC000_0ABC);
      wr(3'd4, 32'h0000_00C2);
      rd(3'd4, v); chk("R2 control readback, clear reads 0", v, 32'h0000_0082);
      rd(3'd5, v); chk("R1 clear empties buffers, A next", v, 32'd6);
   endtask

   task automatic t_pingpong;
      logic [31:0] v;
      int unsigned b;
      want = ack_cnt; b = ack_cnt;
      wr(3'd4, 32'hC2);
      wr(3'd0, 32'h0000_2010); wr(3'd1, 32'h0000_0016);
      rd(3'd5, v); chk("R3 A loaded, B next", v, 32'd2);
      chk("R4 irq while B empty", {31'd0, irq}, 32'd1);
      wr(3'd2, 32'h0000_3040); wr(3'd3, 32'h0000_0044);
      rd(3'd5, v); chk("R4 both loaded, irq low", v, 32'd0);
      want = b + 7;
      wait_acks(b + 7);
      for (int k = 0; k < 4; k++)
         chk("R5 R8 A unit data", {16'd0, rx[8'(b+k)]}, {16'd0, 16'hA008 + 16'(k)});
      for (int k = 0; k < 3; k++)
         chk("R5 R8 B unit data", {16'd0, rx[8'(b+4+k)]}, {16'd0, 16'hA020 + 16'(k)});
      rd(3'd0, v); chk("R6 A address advanced", v, 32'h0000_2018);
      rd(3'd2, v); chk("R6 B address advanced", v, 32'h0000_3046);
      rd(3'd5, v); chk("R5 back on A, both empty", v, 32'd6);
   endtask

   task automatic t_overflow;
      logic [31:0] v;
      int unsigned b;
      want = ack_cnt; b = ack_cnt;
      wr(3'd4, 32'hC2);
      wr(3'd0, 32'h0000_2030); wr(3'd1, 32'h0000_0032);
      want = b + 4;
      wait_acks(b + 2);
      repeat (8) @(negedge clk);
      chk("R7 paused after A", ack_cnt, b + 2);
      rd(3'd5, v); chk("R7 R3 overflow, B next", v, 32'd7);
      wr(3'd2, 32'h0000_3060); wr(3'd3, 32'h0000_0062);
      wait_acks(b + 4);
      chk("R7 resumed count", ack_cnt, b + 4);
      chk("R7 resumed data", {16'd0, rx[8'(b+2)]}, 32'h0000_A030);
      chk("R7 resumed data 2", {16'd0, rx[8'(b+3)]}, 32'h0000_A031);
      rd(3'd5, v); chk("R7 R3 overflow, A next", v, 32'd6);
   endtask

   task automatic t_dev_to_mem;
      logic [31:0] v;
      int unsigned b;
      want = ack_cnt; b = ack_cnt;
      wr(3'd4, 32'hE2);
      wr(3'd0, 32'h0000_2100); wr(3'd1, 32'h0000_0104);
      want = b + 3;
      wait_acks(b + 3);
      for (int k = 0; k < 3; k++)
         chk("R9 memory written", {16'd0, mem[8'h80 + 8'(k)]}, {16'd0, 16'h5A00 + 16'(b + k)});
      chk("R9 R6 word past limit untouched", {16'd0, mem[8'h83]}, 32'h0000_A083);
      rd(3'd5, v); chk("R9 A done, B next", v, 32'd7);
   endtask

   task automatic t_stop;
      logic [31:0] v;
      int unsigned b;
      want = ack_cnt; b = ack_cnt;
      wr(3'd4, 32'hC2);
      wr(3'd0, 32'h0000_2040); wr(3'd1, 32'h8000_0042);
      wr(3'd2, 32'h0000_3080); wr(3'd3, 32'h0000_0082);
      want = b + 4;
      wait_acks(b + 2);
      repeat (8) @(negedge clk);
      chk("R10 no units after stop", ack_cnt, b + 2);
      rd(3'd5, v); chk("R10 finished, irq low", v, 32'd1);
   endtask

   task automatic t_terminal;
      logic [31:0] v;
      int unsigned b;
      want = ack_cnt; b = ack_cnt;
      wr(3'd4, 32'hC2);
      wr(3'd0, 32'h0000_0000); wr(3'd1, 32'hC000_0000);
      want = b + 2;
      repeat (20) @(negedge clk);
      chk("R11 terminal moves nothing", ack_cnt, b);
      rd(3'd5, v); chk("R11 terminal ends channel", v, 32'd4);
   endtask

   task automatic t_disabled;
      logic [31:0] v;
      int unsigned b;
      want = ack_cnt; b = ack_cnt;
      wr(3'd4, 32'h42);
      wr(3'd0, 32'h0000_2050); wr(3'd1, 32'h0000_0050);
      want = b + 1;
      repeat (20) @(negedge clk);
      chk("R12 disabled, no unit", ack_cnt, b);
      rd(3'd5, v); chk("R12 disabled status", v, 32'd0);
      wr(3'd4, 32'h82);
      wait_acks(b + 1);
      chk("R12 enabled, unit data", {16'd0, rx[8'(b)]}, 32'h0000_A028);
      rd(3'd5, v); chk("R12 R5 after single unit", v, 32'd7);
   endtask

   task automatic t_wrap;
      logic [31:0] v;
      int unsigned b;
      want = ack_cnt; b = ack_cnt;
      wr(3'd4, 32'hC2);
      wr(3'd0, 32'h0000_2FFE); wr(3'd1, 32'h0000_0FFE);
      want = b + 1;
      wait_acks(b + 1);
      chk("R6 last unit in page", {16'd0, rx[8'(b)]}, 32'h0000_A0FF);
      rd(3'd0, v); chk("R6 offset wraps, page kept", v, 32'h0000_2000);
   endtask

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = 16'hA000 + 16'(i);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_regs();
      t_pingpong();
      t_overflow();
      t_dev_to_mem();
      t_stop();
      t_terminal();
      t_disabled();
      t_wrap();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      miscompares++;
      $display("FAIL watchdog: run did not complete (R1..all)");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule